// File: doc/BRIEF.md
# Serial Peripheral Byte Controller with Select-Pin Modes

This block moves one byte at a time over a four-wire synchronous serial link and can act as either the clock-driving master or the clocked slave. Clock polarity, clock phase and bit order are set through a configuration write. In master mode the serial clock runs at a rate set by a divisor. Each transfer is framed by a lead interval before the first clock edge and a trail interval after the last edge, and the select line is then held inactive for a guard interval before the next transfer.

The select pin has four behaviours, picked by a direction bit and an output-enable bit. As master it can be an automatic select output, a general-purpose output, a plain input, or an input watched for a mode fault. A mode fault occurs when another device pulls the line low. The block then sets a sticky fault flag, gives up mastership and stops driving the clock and data lines. As slave the pin is always the select input. Software starts a master transfer by writing transmit data. It reads the received byte and a done flag, and gets a collision flag if it writes while a transfer is in progress.

Top module: `spi_ss_ctrl`

## Requirements
- R1: In master mode `sck_o` rests at `cfg_cpol` when no transfer is running. During a transfer it makes exactly 16 transitions, one every `cfg_div`+1 system clocks.
- R2: With `cfg_lsbf`=0 bit 7 of the transmit byte goes out first and the first received bit lands in bit 7. With `cfg_lsbf`=1 bit 0 goes out first and the first received bit lands in bit 0.
- R3: With `cfg_cpha`=0 the first bit is on the data line before the first clock transition, input is captured on odd transitions, and output changes on even ones. With `cfg_cpha`=1 output changes on odd transitions and input is captured on even ones.
- R4: After the eighth captured bit, `rx_data` holds the received byte and `done` is 1 from the next clock on. A `stat_rd` pulse clears `done`.
- R5: Master with `{cfg_ddr,cfg_ssoe}`=2'b11: `ss_oe`=1, and `ss_o` falls `cfg_div`+1 clocks before the first clock transition and rises `cfg_div`+1 clocks after the last one. It then stays high for at least `cfg_div`+1 clocks, and a transmit write in that interval is refused.
- R6: Master with `{cfg_ddr,cfg_ssoe}`=2'b10: `ss_oe`=1 and `ss_o` equals `cfg_gpo`.
- R7: Master with `{cfg_ddr,cfg_ssoe}`=2'b00: a low `ss_i` sets `modf` and clears `mstr_on`, `sck_oe` and `mosi_oe` on the next clock. With 2'b01 the pin is an input (`ss_oe`=0) and a low `ss_i` raises no fault.
- R8: `modf` clears only on a configuration write that follows a `stat_rd` seen while `modf` was 1. A configuration write alone leaves it set.
- R9: A `tx_we` while a transfer is running leaves the byte in flight unchanged and sets `wcol`. `stat_rd` clears `wcol`.
- R10: In slave mode `ss_oe`=0 for every `{cfg_ddr,cfg_ssoe}`. `miso_oe` is 1 only while `ss_i` is low, clock transitions on `sck_i` are ignored while `ss_i` is high, and with `cfg_cpha`=1 the first bit appears on `miso_o` after the first `sck_i` transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Block enable |
| cfg_mstr | input | 1 | 1 selects master, 0 selects slave |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_lsbf | input | 1 | 1 sends least significant bit first |
| cfg_ssoe | input | 1 | Select pin output-enable bit |
| cfg_ddr | input | 1 | Select pin direction bit |
| cfg_gpo | input | 1 | Select pin level in general-purpose output mode |
| cfg_div | input | DIV_W | Half clock period minus one, in system clocks |
| tx_we | input | 1 | Transmit data write strobe |
| tx_data | input | DATA_W | Transmit byte |
| stat_rd | input | 1 | Status read strobe |
| rx_data | output | DATA_W | Last received byte |
| done | output | 1 | Byte complete flag |
| wcol | output | 1 | Write collision flag |
| modf | output | 1 | Mode fault flag |
| mstr_on | output | 1 | Current master bit |
| sck_o | output | 1 | Serial clock out |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Master data in (slave) |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Slave data in (master) |
| ss_o | output | 1 | Select pin out |
| ss_oe | output | 1 | Select pin output enable |
| ss_i | input | 1 | Select pin in |

## Verification
A wrong bit counter or a misplaced shift shows up within one byte. Either `rx_data` differs from the byte the bench model sent, or the captured serial output differs from the written byte. A wrong divisor or sequencer state shows up within one half period as a changed edge spacing or lead/trail count. A faulty pin-mode decode shows at `ss_oe`/`ss_o` in the same cycle. A broken fault path shows one clock after `ss_i` falls, through `modf` and the dropped output enables.

// File: rtl/spi_ss_pkg.sv
package spi_ss_pkg;

    // Select pin behaviour, encoded as {direction bit, output-enable bit}
    typedef enum logic [1:0] {
        SS_SEL_IN = 2'b00,
        SS_RSVD   = 2'b01,
        SS_GPO    = 2'b10,
        SS_AUTO   = 2'b11
    } ss_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_XFER,
        SQ_TRAIL,
        SQ_GAP
    } seq_state_e;

    // Clock transition events: lead = away from idle level, trail = back to it
    typedef struct packed {
        logic lead;
        logic trail;
    } sck_ev_t;

    typedef struct packed {
        logic en;
        logic cpol;
        logic cpha;
        logic lsbf;
        logic ssoe;
        logic ddr;
        logic gpo;
    } mode_cfg_t;

    function automatic ss_mode_e pick_ss_mode(input logic master, input logic ddr,
                                              input logic ssoe);
        return master ? ss_mode_e'({ddr, ssoe}) : SS_SEL_IN;
    endfunction

endpackage

// File: rtl/spi_ss_seq.sv
module spi_ss_seq
    import spi_ss_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             go,
    input  logic [DIV_W-1:0] div,
    output logic             ph,
    output sck_ev_t          ev,
    output logic             sel,
    output logic             idle
);
    localparam int N_EDGES   = 2 * DATA_W;
    localparam int EDGE_W    = $clog2(N_EDGES);
    localparam int LAST_EDGE = N_EDGES - 1;

    seq_state_e       st;
    logic [DIV_W-1:0] cnt;
    logic [EDGE_W-1:0] edges;
    logic             tick;

    assign tick = (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st    <= SQ_IDLE;
            cnt   <= '0;
            ph    <= 1'b0;
            edges <= '0;
        end else begin
            if (st == SQ_IDLE || tick) cnt <= '0;
            else                       cnt <= cnt + 1'b1;
            case (st)
                SQ_IDLE: if (go) begin
                    st    <= SQ_XFER;
                    edges <= '0;
                end
                SQ_XFER: if (tick) begin
                    ph    <= ~ph;
                    edges <= edges + 1'b1;
                    if (edges == EDGE_W'(LAST_EDGE)) st <= SQ_TRAIL;
                end
                SQ_TRAIL: if (tick) st <= SQ_GAP;
                SQ_GAP:   if (tick) st <= SQ_IDLE;
                default:  st <= SQ_IDLE;
            endcase
        end
    end

    assign ev.lead  = (st == SQ_XFER) && tick && !ph;
    assign ev.trail = (st == SQ_XFER) && tick && ph;
    assign sel      = (st == SQ_XFER) || (st == SQ_TRAIL);
    assign idle     = (st == SQ_IDLE);

    // R1
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (st != SQ_XFER) |=> $stable(ph));

endmodule

// File: rtl/spi_ss_shift.sv
module spi_ss_shift
    import spi_ss_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] tx,
    input  logic              lsbf,
    input  logic              cpha,
    input  sck_ev_t           ev,
    input  logic              din,
    input  logic              hold,
    input  logic              clr_done,
    output logic              out_bit,
    output logic [DATA_W-1:0] rx,
    output logic              done
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] sh, nxt, tx_rev, nxt_rev, tx_ord;
    logic [CNT_W-1:0]  bcnt;
    logic              sample, change;

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign tx_rev[i]  = tx[DATA_W-1-i];
        assign nxt_rev[i] = nxt[DATA_W-1-i];
    end

    // Register always shifts toward the top; bit order is handled at load and unload
    assign tx_ord = lsbf ? tx_rev : tx;
    assign nxt    = {sh[DATA_W-2:0], din};
    assign sample = cpha ? ev.trail : ev.lead;
    assign change = cpha ? ev.lead  : ev.trail;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            out_bit <= 1'b0;
            bcnt    <= '0;
            rx      <= '0;
            done    <= 1'b0;
        end else begin
            if (clr_done) done <= 1'b0;
            if (load) begin
                sh      <= tx_ord;
                out_bit <= tx_ord[DATA_W-1];
                bcnt    <= '0;
            end else if (hold) begin
                bcnt <= '0;
            end else begin
                if (sample) begin
                    sh   <= nxt;
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == CNT_W'(DATA_W - 1)) begin
                        rx   <= lsbf ? nxt_rev : nxt;
                        done <= 1'b1;
                    end
                end
                if (change) out_bit <= sh[DATA_W-1];
            end
        end
    end

    // R4
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(sample));

    // R4
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample |=> $stable(rx));

endmodule

// File: rtl/spi_ss_pin.sv
module spi_ss_pin
    import spi_ss_pkg::*;
(
    input  logic master,
    input  logic ddr,
    input  logic ssoe,
    input  logic gpo,
    input  logic sel,
    input  logic ss_i,
    output logic ss_o,
    output logic ss_oe,
    output logic fault
);
    ss_mode_e mode;

    assign mode = pick_ss_mode(master, ddr, ssoe);

    always_comb begin
        case (mode)
            SS_AUTO: begin ss_oe = 1'b1; ss_o = !sel; end
            SS_GPO:  begin ss_oe = 1'b1; ss_o = gpo;  end
            default: begin ss_oe = 1'b0; ss_o = 1'b1; end
        endcase
    end

    assign fault = master && (mode == SS_SEL_IN) && !ss_i;

endmodule

// File: rtl/spi_ss_ctrl.sv
module spi_ss_ctrl
    import spi_ss_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_en,
    input  logic              cfg_mstr,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsbf,
    input  logic              cfg_ssoe,
    input  logic              cfg_ddr,
    input  logic              cfg_gpo,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              done,
    output logic              wcol,
    output logic              modf,
    output logic              mstr_on,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              miso_i,
    output logic              ss_o,
    output logic              ss_oe,
    input  logic              ss_i
);
    mode_cfg_t        mcfg;
    logic [DIV_W-1:0] div_q;
    logic             mstr_q, modf_seen, sck_q;
    logic             mst, slv, slv_active, busy, load, go, abort, fault;
    logic             ph, sel, seq_idle, out_bit;
    sck_ev_t          m_ev, s_ev, ev;

    assign mst        = mcfg.en && mstr_q;
    assign slv        = mcfg.en && !mstr_q;
    assign slv_active = slv && !ss_i;

    assign s_ev.lead  = slv_active && ((sck_i ^ mcfg.cpol) && !(sck_q ^ mcfg.cpol));
    assign s_ev.trail = slv_active && (!(sck_i ^ mcfg.cpol) && (sck_q ^ mcfg.cpol));
    assign ev         = mst ? m_ev : s_ev;

    assign busy  = mst ? !seq_idle : slv_active;
    assign load  = tx_we && mcfg.en && !busy;
    assign go    = load && mst;
    assign abort = fault || !mst;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcfg      <= '0;
            div_q     <= '0;
            mstr_q    <= 1'b0;
            modf      <= 1'b0;
            modf_seen <= 1'b0;
            wcol      <= 1'b0;
            sck_q     <= 1'b0;
        end else begin
            sck_q <= sck_i;
            if (cfg_we) begin
                mcfg   <= '{en: cfg_en, cpol: cfg_cpol, cpha: cfg_cpha, lsbf: cfg_lsbf,
                            ssoe: cfg_ssoe, ddr: cfg_ddr, gpo: cfg_gpo};
                div_q  <= cfg_div;
                mstr_q <= cfg_mstr;
                if (modf_seen) begin
                    modf      <= 1'b0;
                    modf_seen <= 1'b0;
                end
            end
            if (stat_rd) begin
                wcol <= 1'b0;
                if (modf) modf_seen <= 1'b1;
            end
            if (tx_we && busy) wcol <= 1'b1;
            if (fault) begin
                modf      <= 1'b1;
                mstr_q    <= 1'b0;
                modf_seen <= 1'b0;
            end
        end
    end

    spi_ss_seq #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_seq (
        .clk(clk), .rst(rst), .abort(abort), .go(go), .div(div_q),
        .ph(ph), .ev(m_ev), .sel(sel), .idle(seq_idle)
    );

    spi_ss_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .load(load), .tx(tx_data), .lsbf(mcfg.lsbf),
        .cpha(mcfg.cpha), .ev(ev), .din(mst ? miso_i : mosi_i),
        .hold(slv && ss_i), .clr_done(stat_rd),
        .out_bit(out_bit), .rx(rx_data), .done(done)
    );

    spi_ss_pin u_pin (
        .master(mst), .ddr(mcfg.ddr), .ssoe(mcfg.ssoe), .gpo(mcfg.gpo),
        .sel(sel), .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe), .fault(fault)
    );

    assign mstr_on = mstr_q;
    assign sck_o   = mst ? (mcfg.cpol ^ ph) : mcfg.cpol;
    assign sck_oe  = mst;
    assign mosi_o  = out_bit;
    assign mosi_oe = mst;
    assign miso_o  = out_bit;
    assign miso_oe = slv_active;

    // R7
    modf_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(modf) |-> (!sck_oe && !mosi_oe && !mstr_on));

    // R8
    modf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(modf) |-> $past(cfg_we));

    // R9
    wcol_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wcol) |-> $past(tx_we));

endmodule

// File: tb/tb_spi_ss_ctrl.sv
`timescale 1ns/1ps
module tb_spi_ss_ctrl;
    localparam time CLK_P = 20ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 0, cfg_en = 0, cfg_mstr = 0, cfg_cpol = 0, cfg_cpha = 0;
    logic       cfg_lsbf = 0, cfg_ssoe = 0, cfg_ddr = 0, cfg_gpo = 0;
    logic [7:0] cfg_div = '0;
    logic       tx_we = 0;
    logic [7:0] tx_data = '0;
    logic       stat_rd = 0;
    logic [7:0] rx_data;
    logic       done, wcol, modf, mstr_on;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe;
    logic       sck_i = 0, mosi_i = 0, miso_i = 0, ss_i = 1;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_ss_ctrl dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_mstr(cfg_mstr),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsbf(cfg_lsbf), .cfg_ssoe(cfg_ssoe),
        .cfg_ddr(cfg_ddr), .cfg_gpo(cfg_gpo), .cfg_div(cfg_div), .tx_we(tx_we),
        .tx_data(tx_data), .stat_rd(stat_rd), .rx_data(rx_data), .done(done),
        .wcol(wcol), .modf(modf), .mstr_on(mstr_on), .sck_o(sck_o), .sck_oe(sck_oe),
        .sck_i(sck_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i), .ss_o(ss_o),
        .ss_oe(ss_oe), .ss_i(ss_i)
    );

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic       lsbf;
        logic [7:0] div;
        logic [7:0] tx;
        logic [7:0] rxp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 8'd1, 8'hA5, 8'h3C},
        '{1'b0, 1'b1, 1'b0, 8'd2, 8'h81, 8'h7E},
        '{1'b1, 1'b0, 1'b0, 8'd0, 8'h5A, 8'hC3},
        '{1'b1, 1'b1, 1'b1, 8'd3, 8'h1E, 8'hB4},
        '{1'b0, 1'b0, 1'b1, 8'd0, 8'hF0, 8'h0F},
        '{1'b1, 1'b1, 1'b0, 8'd1, 8'h96, 8'h69}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic bitk(input logic [7:0] b, input logic lsbf, input int k);
        return lsbf ? b[k] : b[7-k];
    endfunction

    task automatic cfg_set(input logic en, input logic ms, input logic cpol, input logic cpha,
                           input logic lsbf, input logic ssoe, input logic ddr,
                           input logic gpo, input logic [7:0] div);
        cfg_en = en; cfg_mstr = ms; cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsbf = lsbf;
        cfg_ssoe = ssoe; cfg_ddr = ddr; cfg_gpo = gpo; cfg_div = div;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_rd();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    // Master transfer with a bench slave model on the pins (automatic select mode)
    task automatic mxfer(input vec_t v, input bit inj);
        logic       prev;
        logic [7:0] cap;
        int nsamp, edges, first_e, last_e, rise, bad_gap;
        bit inj_pend;
        cfg_set(1, 1, v.cpol, v.cpha, v.lsbf, 1, 1, 0, v.div);
        pulse_rd();
        chk("R1 sck idle level", sck_o, v.cpol);
        chk("R5 select idle high", ss_o, 1);
        miso_i = v.cpha ? 1'b0 : bitk(v.rxp, v.lsbf, 0);
        tx_data = v.tx;
        tx_we = 1'b1;
        @(negedge clk);
        tx_we = 1'b0;
        chk("R5 select low at start", ss_o, 0);
        prev = v.cpol; cap = '0; nsamp = 0; edges = 0;
        first_e = -1; last_e = 0; rise = -1; bad_gap = 0; inj_pend = 0;
        for (int c = 1; c < 4000 && rise < 0; c++) begin
            @(negedge clk);
            if (inj_pend) begin
                tx_we = 1'b0;
                inj_pend = 0;
                chk("R9 wcol on busy write", wcol, 1);
            end
            if (sck_o !== prev) begin
                edges++;
                if (edges == 1) first_e = c;
                else if (c - last_e != int'(v.div) + 1) bad_gap++;
                last_e = c;
                prev = sck_o;
                if ((sck_o !== v.cpol) == !v.cpha) begin
                    if (nsamp < 8) cap[v.lsbf ? nsamp : 7 - nsamp] = mosi_o;
                    nsamp++;
                end else if (nsamp < 8) begin
                    miso_i = bitk(v.rxp, v.lsbf, nsamp);
                end
                if (inj && edges == 4) begin
                    tx_data = 8'h3F;
                    tx_we = 1'b1;
                    inj_pend = 1;
                end
            end
            if (ss_o === 1'b1 && rise < 0) rise = c;
        end
        chk("R1 transition count", edges, 16);
        chk("R1 half period spacing", bad_gap, 0);
        chk("R5 lead delay", first_e, int'(v.div) + 1);
        chk("R5 trail delay", rise - last_e, int'(v.div) + 1);
        chk("R2 R3 serial output byte", cap, v.tx);
        chk("R2 R3 R4 received byte", rx_data, v.rxp);
        chk("R4 done set", done, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] mcap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        chk("R4 reset done", done, 0);
        chk("R4 reset rx", rx_data, 8'h00);
        chk("R7 reset modf", modf, 0);
        chk("R9 reset wcol", wcol, 0);
        chk("R7 reset sck_oe", sck_oe, 0);
        chk("R10 reset ss_oe", ss_oe, 0);

        // Table of master transfers
        for (int i = 0; i < NV; i++) begin
            mxfer(VECS[i], 1'b0);
            if (i < NV - 1) repeat (int'(VECS[i].div) + 3) @(negedge clk);
        end

        // R5: write during guard interval after select rises is refused
        tx_data = 8'h11;
        tx_we = 1'b1;
        @(negedge clk);
        tx_we = 1'b0;
        chk("R5 guard write refused", wcol, 1);
        chk("R5 guard select high", ss_o, 1);
        repeat (4) @(negedge clk);
        chk("R5 no transfer from guard write", ss_o, 1);

        // R4: status read clears done and wcol
        pulse_rd();
        chk("R4 done cleared", done, 0);
        chk("R9 wcol cleared", wcol, 0);

        // R9: busy write ignored
        mxfer('{1'b0, 1'b1, 1'b0, 8'd2, 8'hC6, 8'h5D}, 1'b1);
        repeat (5) @(negedge clk);

        // R6: general-purpose select output
        cfg_set(1, 1, 0, 0, 0, 0, 1, 0, 8'd1);
        chk("R6 gpo oe", ss_oe, 1);
        chk("R6 gpo low", ss_o, 0);
        cfg_set(1, 1, 0, 0, 0, 0, 1, 1, 8'd1);
        chk("R6 gpo high", ss_o, 1);

        // R7: reserved mode, no fault
        cfg_set(1, 1, 0, 0, 0, 1, 0, 0, 8'd1);
        ss_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 reserved no fault", modf, 0);
        chk("R7 reserved input", ss_oe, 0);
        chk("R7 reserved keeps master", sck_oe, 1);
        ss_i = 1'b1;

        // R7: fault-watch mode
        cfg_set(1, 1, 0, 0, 0, 0, 0, 0, 8'd1);
        chk("R7 armed master", sck_oe, 1);
        chk("R7 armed no fault", modf, 0);
        ss_i = 1'b0;
        @(negedge clk);
        chk("R7 fault flag", modf, 1);
        chk("R7 master dropped", mstr_on, 0);
        chk("R7 sck released", sck_oe, 0);
        chk("R7 mosi released", mosi_oe, 0);
        ss_i = 1'b1;
        @(negedge clk);

        // R8: clear sequence
        cfg_set(1, 1, 0, 0, 0, 0, 0, 0, 8'd1);
        chk("R8 write alone keeps fault", modf, 1);
        pulse_rd();
        chk("R8 read alone keeps fault", modf, 1);
        cfg_set(1, 1, 0, 0, 0, 0, 0, 0, 8'd1);
        chk("R8 read then write clears", modf, 0);
        chk("R8 master restored", sck_oe, 1);

        // R10: slave, CPHA=1, MSB first
        cfg_set(1, 0, 0, 1, 0, 1, 1, 0, 8'd1);
        chk("R10 slave ss input", ss_oe, 0);
        chk("R10 slave no sck drive", sck_oe, 0);
        for (int k = 0; k < 3; k++) begin
            sck_i = 1'b1; @(negedge clk); @(negedge clk);
            chk("R10 miso off while deselected", miso_oe, 0);
            sck_i = 1'b0; @(negedge clk); @(negedge clk);
        end
        tx_data = 8'hC3;
        tx_we = 1'b1;
        @(negedge clk);
        tx_we = 1'b0;
        pulse_rd();
        ss_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 miso on while selected", miso_oe, 1);
        mcap = '0;
        for (int k = 0; k < 8; k++) begin
            sck_i = 1'b1; @(negedge clk); @(negedge clk);
            mcap[7-k] = miso_o;
            mosi_i = bitk(8'h96, 1'b0, k);
            @(negedge clk);
            sck_i = 1'b0; @(negedge clk); @(negedge clk);
        end
        chk("R10 slave output byte", mcap, 8'hC3);
        chk("R10 slave received byte", rx_data, 8'h96);
        chk("R10 slave done", done, 1);
        ss_i = 1'b1;
        @(negedge clk);
        chk("R10 miso off after deselect", miso_oe, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule